// File: doc/BRIEF.md
# Two-Wire Command and Register Slave for an LED Matrix Driver

This block is the serial front end of an LED matrix controller. It listens on a two-wire I2C bus, oversampled on the system clock, and answers one slave address. The upper four address bits are a build-time prefix. The lower three bits come from strap pins. The first byte written after the address is a command. Its high nibble chooses between two kinds of action: changing a control setting (oscillator, display enable and blink rate, shared pin mode and polarity, dimming code) or loading the address pointer for one of three memory regions. The regions are the 16-byte display memory, the 6-byte key-data memory and the single interrupt-flag byte.

Every byte written after the command is display data. It goes to the current pointer, and the pointer then moves forward. During a read, the slave returns the byte at the pointer and advances only when the master acknowledges. The display region wraps from its last byte back to its first. The key region wraps within its six slots. The memories themselves are outside this block: it issues an address, a one-cycle write strobe with data, and a one-cycle read strobe, and it expects read data on the following cycle. While the oscillator bit is clear the block is in standby. In standby only the oscillator command is obeyed.

Top module: `ledCmdSlave`

## Requirements
- R1: After reset the oscillator bit, display enable, blink rate, pin mode and polarity are all 0, the dimming code is 4'hF, and SDA is released.
- R2: The slave drives SDA low in the ninth clock only when the seven address bits equal {prefix 4'b1110, strapAddr}. On a mismatch it never drives SDA and ignores the rest of the transfer. SDA changes only while SCL is low.
- R3: Command high nibble 0x2 sets the oscillator bit from bit 0. Nibble 0x8 sets display enable from bit 0 and blink rate from bits 2:1. Nibble 0xA sets pin mode from bit 0 and polarity from bit 1. Nibble 0xE sets the dimming code from bits 3:0.
- R4: Undefined command bytes change no setting and no pointer. These include any byte whose high nibble is not one of 0x0, 0x2, 0x4, 0x6, 0x8, 0xA, 0xE; key-pointer bytes 0x46, 0x47 and 0x48–0x4F; and 0x61–0x6F.
- R5: While the oscillator bit is 0, every command except nibble 0x2 is ignored, and data bytes cause no memory write.
- R6: Command nibble 0x0 loads the display pointer from bits 3:0. Each data byte after the command produces one write strobe at the pointer, and the pointer then increments, wrapping from 0x0F to 0x00.
- R7: Data bytes sent while the pointer is in the key region (0x40–0x45) or on the flag byte produce no write strobe.
- R8: Read bytes leave MSB first. The pointer advances only when the master acknowledges. A master NACK ends the read, and a later read restarts at the un-advanced pointer.
- R9: Command bytes 0x40–0x45 load the key pointer. Reads in that region wrap from address 0x45 to 0x40.
- R10: A repeated START between a pointer-setting write and a read behaves exactly like a fresh START.
- R11: Command byte 0x60 points reads at memory address 0x60, the interrupt-flag byte, and the pointer stays there across acknowledged reads.
- R12: A STOP in the middle of a byte discards the partial byte without executing it, and the next transfer works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| strapAddr | input | 3 | Strap value for the low three address bits |
| sdaOeLow | output | 1 | 1 pulls the data line low |
| memAddr | output | 7 | Memory address of the current pointer |
| memWrEn | output | 1 | One-cycle display write strobe |
| memWrData | output | 8 | Data for the write strobe |
| memRdEn | output | 1 | One-cycle read request at memAddr |
| memRdData | input | 8 | Read data, valid the cycle after memRdEn |
| oscOn | output | 1 | Oscillator bit; 0 means standby |
| dispOn | output | 1 | Display enable |
| blinkRate | output | 2 | Blink rate code |
| pinIntMode | output | 1 | Shared pin: 0 row driver, 1 interrupt output |
| intActHigh | output | 1 | Interrupt output polarity |
| dimCode | output | 4 | Dimming code |

## Verification
The bench drives a display burst that starts at 0x0E. A pointer that does not wrap, or that wraps at the wrong width, writes to the wrong addresses, and the scoreboard catches the misplaced or missing strobes. A read ending in a NACK is followed by a second read. A slave that advances on the NACK returns the next byte instead of repeating the last one. A key-region read that starts at 0x45 exposes a pointer that runs on to 0x46 instead of wrapping. The bench also checks standby filtering, undefined codes such as 0x47 and 0x61 (a sloppy decode would move the pointer off the display), a mismatched strap address that must draw no ACK, and a STOP cut into a dimming command that must not take effect.

// File: rtl/ledCmdPkg.sv
package ledCmdPkg;
  localparam int MEM_AW = 7;

  localparam logic [3:0] NIB_DISP_PTR = 4'h0;
  localparam logic [3:0] NIB_SYS      = 4'h2;
  localparam logic [3:0] NIB_KEY_PTR  = 4'h4;
  localparam logic [3:0] NIB_FLAG     = 4'h6;
  localparam logic [3:0] NIB_DISP_SET = 4'h8;
  localparam logic [3:0] NIB_PIN      = 4'hA;
  localparam logic [3:0] NIB_DIM      = 4'hE;

  localparam logic [MEM_AW-1:0] KEY_BASE  = 7'h40;
  localparam logic [MEM_AW-1:0] FLAG_ADDR = 7'h60;

  typedef enum logic [1:0] {REG_DISP, REG_KEY, REG_FLAG} ptrRegionT;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX_ADDR, ST_ACK_ADDR, ST_RX_DATA, ST_ACK_DATA, ST_TX_DATA, ST_TX_ACK
  } busStateT;

  // strobes from the bus control to the datapath, each one cycle wide
  typedef struct packed {
    logic sampleBit;  // shift filtered SDA into the receive byte
    logic cmdByte;    // first byte of a write transfer is complete
    logic dataByte;   // a later byte of a write transfer is complete
    logic fetch;      // request read data at the current pointer
    logic loadTx;     // load the transmit byte from read data
    logic shiftTx;    // move to the next transmit bit
    logic advanceRd;  // master acknowledged a read byte
  } busStrobeT;
endpackage

// File: rtl/ledCmdLineFilter.sv
module ledCmdLineFilter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] holdCnt;

  // two-flop synchroniser, then the output follows only a level held FILT_LEN cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      cleanOut <= 1'b1;
      holdCnt  <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == cleanOut) begin
        holdCnt <= '0;
      end else if (holdCnt == CW'(FILT_LEN - 1)) begin
        cleanOut <= syncQ[1];
        holdCnt  <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ledCmdCtrl.sv
module ledCmdCtrl
  import ledCmdPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclF,
  input  logic      sdaF,
  input  logic      addrHit,
  input  logic      rwBit,
  input  logic      txBit,
  output busStrobeT strobes,
  output logic      sdaOeLow
);
  logic     sclQ, sdaQ;
  busStateT state;
  logic [3:0] bitCnt;
  logic     firstByte, gotAck, pendFetch;
  logic     sclRise, sclFall, startSeen, stopSeen;

  assign sclRise   = sclF & ~sclQ;
  assign sclFall   = ~sclF & sclQ;
  assign startSeen = sclF & sclQ & sdaQ & ~sdaF;
  assign stopSeen  = sclF & sclQ & ~sdaQ & sdaF;

  always_comb begin
    strobes       = '0;
    strobes.fetch = pendFetch;
    if (!startSeen && !stopSeen) begin
      case (state)
        ST_RX_ADDR: begin
          if (sclRise && bitCnt < 4'd8) strobes.sampleBit = 1'b1;
          if (sclFall && bitCnt == 4'd8 && addrHit && rwBit) strobes.fetch = 1'b1;
        end
        ST_RX_DATA: begin
          if (sclRise && bitCnt < 4'd8) strobes.sampleBit = 1'b1;
          if (sclFall && bitCnt == 4'd8) begin
            strobes.cmdByte  = firstByte;
            strobes.dataByte = ~firstByte;
          end
        end
        ST_ACK_ADDR: if (sclFall && rwBit) strobes.loadTx = 1'b1;
        ST_TX_DATA:  if (sclFall && bitCnt != 4'd7) strobes.shiftTx = 1'b1;
        ST_TX_ACK: begin
          if (sclRise && !sdaF) strobes.advanceRd = 1'b1;
          if (sclFall && gotAck) strobes.loadTx = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_ACK_ADDR, ST_ACK_DATA: sdaOeLow = 1'b1;
      ST_TX_DATA:               sdaOeLow = ~txBit;
      default:                  sdaOeLow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
      state     <= ST_IDLE;
      bitCnt    <= '0;
      firstByte <= 1'b0;
      gotAck    <= 1'b0;
      pendFetch <= 1'b0;
    end else begin
      sclQ      <= sclF;
      sdaQ      <= sdaF;
      pendFetch <= strobes.advanceRd;
      if (startSeen) begin
        state  <= ST_RX_ADDR;
        bitCnt <= '0;
      end else if (stopSeen) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_RX_ADDR: begin
            if (sclRise) bitCnt <= bitCnt + 4'd1;
            else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              state  <= addrHit ? ST_ACK_ADDR : ST_IDLE;
            end
          end
          ST_ACK_ADDR: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (rwBit) begin
                state <= ST_TX_DATA;
              end else begin
                state     <= ST_RX_DATA;
                firstByte <= 1'b1;
              end
            end
          end
          ST_RX_DATA: begin
            if (sclRise) bitCnt <= bitCnt + 4'd1;
            else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              state  <= ST_ACK_DATA;
            end
          end
          ST_ACK_DATA: begin
            if (sclFall) begin
              state     <= ST_RX_DATA;
              firstByte <= 1'b0;
            end
          end
          ST_TX_DATA: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                state  <= ST_TX_ACK;
                bitCnt <= '0;
              end else begin
                bitCnt <= bitCnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (sclRise) gotAck <= ~sdaF;
            else if (sclFall) begin
              bitCnt <= '0;
              state  <= gotAck ? ST_TX_DATA : ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ledCmdDatapath.sv
module ledCmdDatapath
  import ledCmdPkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b1110,
  parameter int         KEY_SLOTS   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaF,
  input  logic [2:0]        strapAddr,
  input  busStrobeT         strobes,
  output logic              addrHit,
  output logic              rwBit,
  output logic              txBit,
  output logic [MEM_AW-1:0] memAddr,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  output logic              memRdEn,
  input  logic [7:0]        memRdData,
  output logic              oscOn,
  output logic              dispOn,
  output logic [1:0]        blinkRate,
  output logic              pinIntMode,
  output logic              intActHigh,
  output logic [3:0]        dimCode
);
  localparam logic [2:0] KEY_END = 3'(KEY_SLOTS - 1);

  logic [7:0] rxByte, txByte;
  ptrRegionT  region;
  logic [3:0] offset;
  logic [3:0] cmdNib;

  assign cmdNib  = rxByte[7:4];
  assign addrHit = (rxByte[7:1] == {ADDR_PREFIX, strapAddr});
  assign rwBit   = rxByte[0];
  assign txBit   = txByte[7];

  function automatic logic [3:0] nextOffset(input ptrRegionT r, input logic [3:0] o);
    case (r)
      REG_DISP: nextOffset = o + 4'd1;
      REG_KEY:  nextOffset = (o[2:0] == KEY_END) ? 4'd0 : o + 4'd1;
      default:  nextOffset = o;
    endcase
  endfunction

  always_comb begin
    case (region)
      REG_DISP: memAddr = {3'b000, offset};
      REG_KEY:  memAddr = KEY_BASE | {4'b0000, offset[2:0]};
      default:  memAddr = FLAG_ADDR;
    endcase
  end

  assign memWrEn   = strobes.dataByte & oscOn & (region == REG_DISP);
  assign memWrData = rxByte;
  assign memRdEn   = strobes.fetch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte     <= '0;
      txByte     <= '0;
      region     <= REG_DISP;
      offset     <= '0;
      oscOn      <= 1'b0;
      dispOn     <= 1'b0;
      blinkRate  <= 2'b00;
      pinIntMode <= 1'b0;
      intActHigh <= 1'b0;
      dimCode    <= 4'hF;
    end else begin
      if (strobes.sampleBit) rxByte <= {rxByte[6:0], sdaF};
      if (strobes.loadTx)       txByte <= memRdData;
      else if (strobes.shiftTx) txByte <= {txByte[6:0], 1'b0};

      // standby filter: only the oscillator command passes while oscOn is low
      if (strobes.cmdByte && (oscOn || cmdNib == NIB_SYS)) begin
        case (cmdNib)
          NIB_DISP_PTR: begin
            region <= REG_DISP;
            offset <= rxByte[3:0];
          end
          NIB_SYS: oscOn <= rxByte[0];
          NIB_KEY_PTR: begin
            if (!rxByte[3] && rxByte[2:0] <= KEY_END) begin
              region <= REG_KEY;
              offset <= {1'b0, rxByte[2:0]};
            end
          end
          NIB_FLAG: begin
            if (rxByte[3:0] == 4'h0) begin
              region <= REG_FLAG;
              offset <= '0;
            end
          end
          NIB_DISP_SET: begin
            dispOn    <= rxByte[0];
            blinkRate <= rxByte[2:1];
          end
          NIB_PIN: begin
            pinIntMode <= rxByte[0];
            intActHigh <= rxByte[1];
          end
          NIB_DIM: dimCode <= rxByte[3:0];
          default: ;
        endcase
      end

      if ((strobes.dataByte && oscOn) || strobes.advanceRd)
        offset <= nextOffset(region, offset);
    end
  end
endmodule

// File: rtl/ledCmdSlave.sv
module ledCmdSlave
  import ledCmdPkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b1110,
  parameter int         FILT_LEN    = 3,
  parameter int         KEY_SLOTS   = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [2:0]  strapAddr,
  output logic        sdaOeLow,
  output logic [6:0]  memAddr,
  output logic        memWrEn,
  output logic [7:0]  memWrData,
  output logic        memRdEn,
  input  logic [7:0]  memRdData,
  output logic        oscOn,
  output logic        dispOn,
  output logic [1:0]  blinkRate,
  output logic        pinIntMode,
  output logic        intActHigh,
  output logic [3:0]  dimCode
);
  localparam int LINES = 2;

  logic [LINES-1:0] rawLines, cleanLines;
  busStrobeT        strobes;
  logic             addrHit, rwBit, txBit;

  assign rawLines = {sdaIn, sclIn};

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_line
      ledCmdLineFilter #(.FILT_LEN(FILT_LEN)) i_filt (
        .clk      (clk),
        .rstN     (rstN),
        .rawIn    (rawLines[g]),
        .cleanOut (cleanLines[g])
      );
    end
  endgenerate

  ledCmdCtrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclF     (cleanLines[0]),
    .sdaF     (cleanLines[1]),
    .addrHit  (addrHit),
    .rwBit    (rwBit),
    .txBit    (txBit),
    .strobes  (strobes),
    .sdaOeLow (sdaOeLow)
  );

  ledCmdDatapath #(.ADDR_PREFIX(ADDR_PREFIX), .KEY_SLOTS(KEY_SLOTS)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sdaF       (cleanLines[1]),
    .strapAddr  (strapAddr),
    .strobes    (strobes),
    .addrHit    (addrHit),
    .rwBit      (rwBit),
    .txBit      (txBit),
    .memAddr    (memAddr),
    .memWrEn    (memWrEn),
    .memWrData  (memWrData),
    .memRdEn    (memRdEn),
    .memRdData  (memRdData),
    .oscOn      (oscOn),
    .dispOn     (dispOn),
    .blinkRate  (blinkRate),
    .pinIntMode (pinIntMode),
    .intActHigh (intActHigh),
    .dimCode    (dimCode)
  );
endmodule

// File: rtl/ledCmdSlaveChk.sv
module ledCmdSlaveChk #(
  parameter int KEY_SLOTS = 6
) (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOeLow,
  input logic       memWrEn,
  input logic       memRdEn,
  input logic [6:0] memAddr,
  input logic       oscOn,
  input logic       dispOn,
  input logic [3:0] dimCode
);
  localparam logic [2:0] KEY_END = 3'(KEY_SLOTS - 1);

  // R2: the slave never moves the data line while the bus clock is high
  p_sda_scl_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOeLow) |-> !sclIn);

  // R5: nothing but the oscillator bit moves during standby
  p_standby_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    !oscOn |=> ($stable(dimCode) && $stable(dispOn)));

  // R7: write strobes only ever address the display region
  p_write_display_r7: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memAddr[6:4] == 3'b000));

  // R8: reads and writes never coincide
  p_no_rd_wr_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  // R9: key-region fetches stay inside the key slots
  p_key_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && memAddr[6:4] == 3'b100) |-> (memAddr[3] == 1'b0 && memAddr[2:0] <= KEY_END));
endmodule

bind ledCmdSlave ledCmdSlaveChk #(.KEY_SLOTS(KEY_SLOTS)) i_chk (.*);

// File: tb/test_ledCmdSlave.sv
module test_ledCmdSlave;
  localparam int Q = 16;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] ADDR_W = {4'b1110, STRAP, 1'b0};
  localparam logic [7:0] ADDR_R = {4'b1110, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sdaOeLow, memWrEn, memRdEn, oscOn, dispOn, pinIntMode, intActHigh;
  logic [6:0] memAddr;
  logic [7:0] memWrData, memRdData;
  logic [1:0] blinkRate;
  logic [3:0] dimCode;
  logic sdaLine;
  logic flagBit = 1'b1;
  logic [7:0] dispMem [16];
  logic [14:0] expWr [$];
  int checks = 0, fails = 0;

  assign sdaLine = sdaDrv & ~sdaOeLow;

  always #4 clk = ~clk;

  ledCmdSlave i_ledCmdSlave (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .strapAddr(STRAP),
    .sdaOeLow(sdaOeLow), .memAddr(memAddr), .memWrEn(memWrEn), .memWrData(memWrData),
    .memRdEn(memRdEn), .memRdData(memRdData), .oscOn(oscOn), .dispOn(dispOn),
    .blinkRate(blinkRate), .pinIntMode(pinIntMode), .intActHigh(intActHigh), .dimCode(dimCode)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] keyVal(input logic [2:0] a);
    return 8'hC0 | {5'b0, a};
  endfunction

  // memory model: display array, key pattern, flag byte; read data one cycle after the request
  initial for (int i = 0; i < 16; i++) dispMem[i] = 8'h50 + 8'(i);

  always @(negedge clk) begin
    if (rstN && memRdEn) begin
      if (memAddr < 7'h10)       memRdData <= dispMem[memAddr[3:0]];
      else if (memAddr[6:4] == 3'b100) memRdData <= keyVal(memAddr[2:0]);
      else if (memAddr == 7'h60) memRdData <= {8{flagBit}};
      else                       memRdData <= 8'hEE;
    end
  end

  // scoreboard monitor for write strobes
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      dispMem[memAddr[3:0]] <= memWrData;
      if (expWr.size() == 0) begin
        check("R5/R7 unexpected write", {17'd0, memAddr, memWrData}, 32'h0);
      end else begin
        logic [14:0] item;
        item = expWr.pop_front();
        check("R6 write strobe", {17'd0, memAddr, memWrData}, {17'd0, item});
      end
    end
  end

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();
    waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaDrv = b[i]; waitQ();
      sclDrv = 1'b1; waitQ(); waitQ();
      sclDrv = 1'b0; waitQ();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackd);
    sendBits(b, 8);
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    ackd = ~sdaLine; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    sdaDrv = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); sclDrv = 1'b1;
      waitQ(); b[i] = sdaLine;
      waitQ(); sclDrv = 1'b0;
    end
    waitQ(); sdaDrv = ackIt ? 1'b0 : 1'b1;
    waitQ(); sclDrv = 1'b1;
    waitQ(); waitQ(); sclDrv = 1'b0;
    waitQ(); sdaDrv = 1'b1;
  endtask

  task automatic sendChecked(input logic [7:0] b, input string req);
    logic a;
    sendByte(b, a);
    check(req, {31'd0, a}, 32'd1);
  endtask

  task automatic recvChecked(input logic ackIt, input logic [7:0] exp, input string req);
    logic [7:0] d;
    recvByte(ackIt, d);
    check(req, {24'd0, d}, {24'd0, exp});
  endtask

  task automatic doWrite(input logic [7:0] cmd, input string req);
    busStart();
    sendChecked(ADDR_W, "R2 address ack");
    sendChecked(cmd, req);
    busStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic a;
    memRdData = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 oscOn", {31'd0, oscOn}, 32'd0);
    check("R1 dispOn", {31'd0, dispOn}, 32'd0);
    check("R1 blinkRate", {30'd0, blinkRate}, 32'd0);
    check("R1 pin mode/polarity", {30'd0, pinIntMode, intActHigh}, 32'd0);
    check("R1 dimCode", {28'd0, dimCode}, 32'hF);
    check("R1 sda released", {31'd0, sdaOeLow}, 32'd0);

    // R5 standby: display command and data write ignored
    doWrite(8'h85, "R5 ack in standby");
    check("R5 dispOn frozen", {31'd0, dispOn}, 32'd0);
    busStart();
    sendChecked(ADDR_W, "R5 address ack");
    sendChecked(8'h03, "R5 cmd ack");
    sendChecked(8'h77, "R5 data ack");
    busStop();

    // R2 wrong strap: no ack, rest ignored
    busStart();
    sendByte({4'b1110, 3'b010, 1'b0}, a);
    check("R2 no ack on mismatch", {31'd0, a}, 32'd0);
    sendByte(8'h21, a);
    check("R2 ignored byte no ack", {31'd0, a}, 32'd0);
    busStop();
    check("R2 oscOn unchanged", {31'd0, oscOn}, 32'd0);

    // R3 register commands
    doWrite(8'h21, "R3 cmd ack");
    check("R3 oscOn set", {31'd0, oscOn}, 32'd1);
    doWrite(8'h85, "R3 cmd ack");
    check("R3 display set", {29'd0, dispOn, blinkRate}, {29'd0, 1'b1, 2'b10});
    doWrite(8'hA3, "R3 cmd ack");
    check("R3 pin set", {30'd0, pinIntMode, intActHigh}, 32'd3);
    doWrite(8'hE7, "R3 cmd ack");
    check("R3 dimCode", {28'd0, dimCode}, 32'h7);

    // R6 display burst with wrap
    expWr.push_back({7'h0E, 8'hD0});
    expWr.push_back({7'h0F, 8'hD1});
    expWr.push_back({7'h00, 8'hD2});
    expWr.push_back({7'h01, 8'hD3});
    busStart();
    sendChecked(ADDR_W, "R6 address ack");
    sendChecked(8'h0E, "R6 cmd ack");
    sendChecked(8'hD0, "R6 data ack");
    sendChecked(8'hD1, "R6 data ack");
    sendChecked(8'hD2, "R6 data ack");
    sendChecked(8'hD3, "R6 data ack");
    busStop();
    check("R6 all writes seen", expWr.size(), 32'd0);

    // R4 undefined codes leave settings and pointer (now 0x02)
    doWrite(8'hC5, "R4 ack");
    doWrite(8'h47, "R4 ack");
    doWrite(8'h61, "R4 ack");
    doWrite(8'h9E, "R4 ack");
    check("R4 settings kept", {22'd0, oscOn, dispOn, blinkRate, pinIntMode, intActHigh, dimCode},
          {22'd0, 1'b1, 1'b1, 2'b10, 1'b1, 1'b1, 4'h7});
    busStart();
    sendChecked(ADDR_R, "R4 read address ack");
    recvChecked(1'b0, 8'h52, "R4 pointer kept at 0x02");
    busStop();

    // R8/R10 read with repeated start, wrap, NACK stops advance
    busStart();
    sendChecked(ADDR_W, "R10 address ack");
    sendChecked(8'h0F, "R10 cmd ack");
    busStart();
    sendChecked(ADDR_R, "R10 read address ack after Sr");
    recvChecked(1'b1, 8'hD1, "R10 first read byte");
    recvChecked(1'b1, 8'hD2, "R8 wrapped read byte");
    recvChecked(1'b0, 8'hD3, "R8 last read byte");
    busStop();
    busStart();
    sendChecked(ADDR_R, "R8 address ack");
    recvChecked(1'b0, 8'hD3, "R8 no advance on NACK");
    busStop();

    // R7/R9 key region: write ignored, read wraps 0x45 -> 0x40
    busStart();
    sendChecked(ADDR_W, "R7 address ack");
    sendChecked(8'h44, "R7 cmd ack");
    sendChecked(8'h55, "R7 data ack");
    busStart();
    sendChecked(ADDR_R, "R9 read address ack");
    recvChecked(1'b1, keyVal(3'd5), "R9 key slot 5");
    recvChecked(1'b1, keyVal(3'd0), "R9 key wrap to 0x40");
    recvChecked(1'b0, keyVal(3'd1), "R9 key slot 1");
    busStop();

    // R11 interrupt flag byte
    busStart();
    sendChecked(ADDR_W, "R11 address ack");
    sendChecked(8'h60, "R11 cmd ack");
    busStart();
    sendChecked(ADDR_R, "R11 read address ack");
    recvChecked(1'b1, 8'hFF, "R11 flag set");
    recvChecked(1'b0, 8'hFF, "R11 flag pointer holds");
    busStop();
    flagBit = 1'b0;
    busStart();
    sendChecked(ADDR_R, "R11 read address ack");
    recvChecked(1'b0, 8'h00, "R11 flag clear");
    busStop();

    // R12 STOP inside a byte
    busStart();
    sendChecked(ADDR_W, "R12 address ack");
    sendBits(8'hE2, 4);
    busStop();
    check("R12 partial byte discarded", {28'd0, dimCode}, 32'h7);
    doWrite(8'hE2, "R12 next transfer ack");
    check("R12 next transfer works", {28'd0, dimCode}, 32'h2);

    // R5 back to standby
    doWrite(8'h20, "R5 cmd ack");
    check("R5 oscOn cleared", {31'd0, oscOn}, 32'd0);
    doWrite(8'hE9, "R5 cmd ack");
    check("R5 dimCode frozen", {28'd0, dimCode}, 32'h2);
    busStart();
    sendChecked(ADDR_W, "R5 address ack");
    sendChecked(8'h00, "R5 cmd ack");
    sendChecked(8'h12, "R5 data ack");
    busStop();
    repeat (10) @(negedge clk);
    check("R6 no pending writes", expWr.size(), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule